// File: doc/BRIEF.md
# Single-Cycle Word-Datapath Processor Core

This block is a 32-bit processor core that fetches, decodes and retires one instruction on every rising clock edge. It implements eight operations: five register-to-register arithmetic and logic operations (add, subtract, and, or, signed set-on-less-than), a word load, a word store and a branch taken when two registers are equal. Instruction and data memories sit outside the core on separate ports. Each port carries 32-bit words and is addressed by byte addresses whose bits [31:2] select the word. The instruction port is read only and returns its word in the same cycle. The data port also returns read data combinationally and takes a write at the clock edge.

Inside the core are the program counter, a 32-entry register file with two read ports and one write port, the ALU, a sign extender, a dedicated branch-target adder, the datapath selectors and a flat combinational decoder. The decoder turns opcode and function code directly into a 3-bit ALU code and all steering controls. Any encoding it does not recognise retires as a no-op.

Top module: `sc_core`

## Requirements
- R1: While `rst_n` is low at a rising edge the PC becomes 0, so `imem_addr` is 0 once reset is held. No data-memory write is issued while `rst_n` is low.
- R2: For every instruction other than a taken branch, the next fetch address is the current one plus 4.
- R3: Branch-if-equal (opcode 000100) with equal `rs` [25:21] and `rt` [20:16] registers jumps to PC+4 plus the sign-extended 16-bit field [15:0] shifted left by two. When the registers differ it falls through to PC+4.
- R4: Opcode 000000 executes by func [5:0]: 100000 add, 100010 subtract, 100100 and, 100101 or. The result is written to register `rd` [15:11].
- R5: func 101010 compares `rs` and `rt` as signed two's-complement values and writes 1 to `rd` if rs < rt, otherwise 0.
- R6: Load (opcode 100011) drives `dmem_addr` = rs + sext(imm), raises `dmem_ren`, and writes `dmem_rdata` into register `rt`.
- R7: Store (opcode 101011) drives `dmem_addr` = rs + sext(imm) and `dmem_wdata` = register `rt`, raises `dmem_wen`, and writes no register.
- R8: The immediate is sign-extended from bit 15, so 0xFFFC acts as -4 in address and branch arithmetic.
- R9: Register 0 always reads as zero, and writes to it are discarded.
- R10: An unknown opcode, or opcode 000000 with an unknown func, writes no register and no memory and advances the PC by 4.
- R11: `dmem_wen` and `dmem_ren` are never high together, and both stay low for instructions other than store and load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| imem_addr | output | 32 | Byte address of the instruction being executed (the PC) |
| imem_rdata | input | 32 | Instruction word at `imem_addr`, same cycle |
| dmem_addr | output | 32 | Byte address of the data access |
| dmem_wdata | output | 32 | Store data |
| dmem_wen | output | 1 | Write the store data at the next rising edge |
| dmem_ren | output | 1 | Load in progress |
| dmem_rdata | input | 32 | Data word at `dmem_addr`, same cycle |

## Verification
The assertions assume that both memories answer combinationally in the cycle the address is presented, and that the instruction word is stable between edges. The bench meets this by driving `imem_rdata` and `dmem_rdata` from continuous reads of its own arrays and by updating its data array only at rising edges while `dmem_wen` is high. Random programs use registers 0 to 7 only. Every program starts by loading those registers from preloaded data, so the bench model knows every value the core can read. Branch offsets are kept small and never equal -1, so that control flow keeps moving through the wrapped instruction array.

// File: rtl/sc_core_pkg.sv
// Package: shared encodings and the control bundle for the single-cycle core.
// Assumes the fixed 32-bit instruction layout: op[31:26] rs[25:21] rt[20:16]
// rd[15:11] func[5:0] imm[15:0].
package sc_core_pkg;

    localparam int XLEN    = 32;
    localparam int REG_CNT = 32;
    localparam int REG_AW  = $clog2(REG_CNT);
    localparam int OP_W    = 6;
    localparam int FN_W    = 6;
    localparam int IMM_W   = 16;

    // ALU operation codes (values fixed by the decoder/ALU contract)
    typedef enum logic [2:0] {
        ALU_AND = 3'b000,
        ALU_OR  = 3'b001,
        ALU_ADD = 3'b010,
        ALU_SUB = 3'b110,
        ALU_SLT = 3'b111
    } alu_op_e;

    localparam logic [OP_W-1:0] OPC_RTYPE = 6'b000000;
    localparam logic [OP_W-1:0] OPC_LOAD  = 6'b100011;
    localparam logic [OP_W-1:0] OPC_STORE = 6'b101011;
    localparam logic [OP_W-1:0] OPC_BEQ   = 6'b000100;

    localparam logic [FN_W-1:0] FN_ADD = 6'b100000;
    localparam logic [FN_W-1:0] FN_SUB = 6'b100010;
    localparam logic [FN_W-1:0] FN_AND = 6'b100100;
    localparam logic [FN_W-1:0] FN_OR  = 6'b100101;
    localparam logic [FN_W-1:0] FN_SLT = 6'b101010;

    // Steering controls produced by the decoder for one instruction
    typedef struct packed {
        logic    reg_we;      // write the register file
        logic    dst_is_rd;   // 1: write rd, 0: write rt
        logic    b_is_imm;    // 1: ALU B is sign-extended immediate
        logic    mem_we;      // store
        logic    mem_re;      // load
        logic    wb_from_mem; // 1: write-back data from memory
        logic    is_branch;   // branch-if-equal
        logic    illegal;     // unrecognised encoding
        alu_op_e alu_op;
    } ctrl_t;

endpackage

// File: rtl/sc_decoder.sv
// Module: flat control decoder.
// Maps opcode and func straight to every datapath control, including the
// 3-bit ALU code, in one level. The branch-select output combines the branch
// flag with the ALU zero flag. Unknown encodings produce an all-quiet control
// word with only the illegal flag set.
module sc_decoder
    import sc_core_pkg::*;
(
    input  logic [OP_W-1:0] op,
    input  logic [FN_W-1:0] func,
    input  logic            alu_zero,
    output ctrl_t           ctrl,
    output logic            pc_src
);

    // Decode opcode, and func for register-register forms
    always_comb begin
        ctrl        = '0;
        ctrl.alu_op = ALU_ADD;
        case (op)
            OPC_RTYPE: begin
                ctrl.reg_we    = 1'b1;
                ctrl.dst_is_rd = 1'b1;
                case (func)
                    FN_ADD:  ctrl.alu_op = ALU_ADD;
                    FN_SUB:  ctrl.alu_op = ALU_SUB;
                    FN_AND:  ctrl.alu_op = ALU_AND;
                    FN_OR:   ctrl.alu_op = ALU_OR;
                    FN_SLT:  ctrl.alu_op = ALU_SLT;
                    default: begin
                        ctrl.reg_we    = 1'b0;
                        ctrl.dst_is_rd = 1'b0;
                        ctrl.illegal   = 1'b1;
                    end
                endcase
            end
            OPC_LOAD: begin
                ctrl.reg_we      = 1'b1;
                ctrl.b_is_imm    = 1'b1;
                ctrl.mem_re      = 1'b1;
                ctrl.wb_from_mem = 1'b1;
            end
            OPC_STORE: begin
                ctrl.b_is_imm = 1'b1;
                ctrl.mem_we   = 1'b1;
            end
            OPC_BEQ: begin
                ctrl.is_branch = 1'b1;
                ctrl.alu_op    = ALU_SUB;
            end
            default: ctrl.illegal = 1'b1;
        endcase
    end

    // Take the branch only on equality
    always_comb pc_src = ctrl.is_branch & alu_zero;

endmodule

// File: rtl/sc_alu.sv
// Module: five-function ALU with zero flag.
// Purely combinational. Assumes codes outside the five defined ones are not
// issued; they yield zero.
module sc_alu
    import sc_core_pkg::*;
#(
    parameter int W = XLEN
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y,
    output logic         zero
);

    // Select the result for the requested function
    always_comb begin
        case (op)
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = '0;
        endcase
    end

    // Flag an all-zero result for equality tests
    always_comb zero = (y == '0);

endmodule

// File: rtl/sc_regfile.sv
// Module: register file, two combinational read ports and one write port.
// Entry 0 is not stored: it reads as zero and drops writes. Writes land on
// the rising edge when we is high. A read of the entry being written returns
// the old value in that cycle.
module sc_regfile
    import sc_core_pkg::*;
#(
    parameter int W     = XLEN,
    parameter int DEPTH = REG_CNT,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic [AW-1:0] ra_a,
    input  logic [AW-1:0] ra_b,
    output logic [W-1:0]  rd_a,
    output logic [W-1:0]  rd_b,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd
);

    logic [W-1:0] regs [1:DEPTH-1];

    // Store a write-back value into one non-zero entry
    always_ff @(posedge clk) begin
        if (we && (wa != '0)) begin
            regs[wa] <= wd;
        end
    end

    // Port A read, entry 0 hardwired to zero
    always_comb rd_a = (ra_a == '0) ? '0 : regs[ra_a];

    // Port B read, entry 0 hardwired to zero
    always_comb rd_b = (ra_b == '0) ? '0 : regs[ra_b];

endmodule

// File: rtl/sc_core.sv
// Module: single-cycle core top.
// Retires one instruction per rising edge. Assumes both memories answer
// combinationally within the cycle. Reset is synchronous and active low. It
// clears only the PC and blocks register and memory writes while held.
module sc_core
    import sc_core_pkg::*;
#(
    parameter int XW = XLEN,
    parameter int NREG = REG_CNT,
    localparam int RAW = $clog2(NREG),
    localparam int IW  = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [XW-1:0] imem_addr,
    input  logic [IW-1:0] imem_rdata,
    output logic [XW-1:0] dmem_addr,
    output logic [XW-1:0] dmem_wdata,
    output logic          dmem_wen,
    output logic          dmem_ren,
    input  logic [XW-1:0] dmem_rdata
);

    logic [XW-1:0]  pc, pc_plus4, pc_next, br_target;
    logic [XW-1:0]  imm_sx, imm_off;
    logic [RAW-1:0] rs, rt, rd, wb_addr;
    logic [XW-1:0]  rs_val, rt_val, alu_b, alu_y, wb_data;
    logic           alu_zero, pc_src, wb_en;
    ctrl_t          ctrl;

    // Program counter, loaded every cycle
    always_ff @(posedge clk) begin
        if (!rst_n) pc <= '0;
        else        pc <= pc_next;
    end

    // Instruction fields
    always_comb begin
        rs = imem_rdata[25:21];
        rt = imem_rdata[20:16];
        rd = imem_rdata[15:11];
    end

    // Sign extension of the immediate and its word-offset form
    always_comb begin
        imm_sx  = {{(XW-IMM_W){imem_rdata[IMM_W-1]}}, imem_rdata[IMM_W-1:0]};
        imm_off = {imm_sx[XW-3:0], 2'b00};
    end

    // Sequential and branch-target adders, and next-PC select
    always_comb begin
        pc_plus4  = pc + XW'(4);
        br_target = pc_plus4 + imm_off;
        pc_next   = pc_src ? br_target : pc_plus4;
    end

    sc_decoder i_dec (
        .op       (imem_rdata[31:26]),
        .func     (imem_rdata[5:0]),
        .alu_zero (alu_zero),
        .ctrl     (ctrl),
        .pc_src   (pc_src)
    );

    sc_regfile #(.W(XW), .DEPTH(NREG)) i_rf (
        .clk  (clk),
        .ra_a (rs),
        .ra_b (rt),
        .rd_a (rs_val),
        .rd_b (rt_val),
        .we   (wb_en),
        .wa   (wb_addr),
        .wd   (wb_data)
    );

    // ALU second-operand select
    always_comb alu_b = ctrl.b_is_imm ? imm_sx : rt_val;

    sc_alu #(.W(XW)) i_alu (
        .op   (ctrl.alu_op),
        .a    (rs_val),
        .b    (alu_b),
        .y    (alu_y),
        .zero (alu_zero)
    );

    // Write-back address, data and enable
    always_comb begin
        wb_addr = ctrl.dst_is_rd ? rd : rt;
        wb_data = ctrl.wb_from_mem ? dmem_rdata : alu_y;
        wb_en   = ctrl.reg_we & rst_n;
    end

    // Memory and fetch ports
    always_comb begin
        imem_addr  = pc;
        dmem_addr  = alu_y;
        dmem_wdata = rt_val;
        dmem_wen   = ctrl.mem_we & rst_n;
        dmem_ren   = ctrl.mem_re;
    end

    AST_RESET_PC: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (imem_addr == '0));                                   // R1
    AST_SEQ_PC: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(pc_src)) |-> (imem_addr == $past(imem_addr) + XW'(4))); // R2
    AST_BRANCH_PC: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(pc_src)) |->
        (imem_addr == $past(imem_addr) + XW'(4) + $past(imm_off)));           // R3
    AST_SLT_BOOL: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.alu_op == ALU_SLT) |-> (alu_y[XW-1:1] == '0));                 // R5
    AST_STORE_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_wen |-> !wb_en);                                                // R7
    AST_ZERO_REG: assert property (@(posedge clk) disable iff (!rst_n)
        (rs == '0) |-> (rs_val == '0));                                      // R9
    AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.illegal |-> (!wb_en && !dmem_wen && !pc_src));                  // R10
    AST_MEM_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(dmem_wen && dmem_ren));                                            // R11

endmodule

// File: tb/test_sc_core.sv
// Bench: directed program with hard-coded results, then random programs
// checked cycle by cycle against an instruction-level model.
module test_sc_core;

    localparam int CLK_PERIOD = 10;
    localparam int MEM_WORDS  = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
    logic        dmem_wen, dmem_ren;

    logic [31:0] imem [MEM_WORDS];
    logic [31:0] dmem [MEM_WORDS];
    logic [31:0] mdmem [MEM_WORDS];
    logic [31:0] mreg [32];
    logic [31:0] mpc;
    bit          last_branch;
    int          n_run = 0;
    int          n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sc_core i_sc_core (
        .clk(clk), .rst_n(rst_n),
        .imem_addr(imem_addr), .imem_rdata(imem_rdata),
        .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata),
        .dmem_wen(dmem_wen), .dmem_ren(dmem_ren), .dmem_rdata(dmem_rdata)
    );

    assign imem_rdata = imem[imem_addr[7:2]];
    assign dmem_rdata = dmem[dmem_addr[7:2]];

    always @(posedge clk) begin
        if (rst_n && dmem_wen) dmem[dmem_addr[7:2]] <= dmem_wdata;
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
        return {6'b0, 5'(rs), 5'(rt), 5'(rd), 5'b0, fn};
    endfunction

    function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, logic [15:0] imm);
        return {op, 5'(rs), 5'(rt), imm};
    endfunction

    // Check the ports against the model for the current instruction, then retire it in the model
    task automatic step_and_check();
        logic [31:0] ins, sx, a, b, ea, res, nxt;
        logic [5:0]  op, fn;
        int          rs, rt, rd, dst;
        bit          we_e, re_e, wr, valid;
        string       tg;
        ins = imem[mpc[7:2]];
        op = ins[31:26]; fn = ins[5:0];
        rs = int'(ins[25:21]); rt = int'(ins[20:16]); rd = int'(ins[15:11]);
        sx = {{16{ins[15]}}, ins[15:0]};
        a = mreg[rs]; b = mreg[rt];
        nxt = mpc + 32'd4; we_e = 0; re_e = 0; wr = 0; valid = 1; res = '0; ea = '0; dst = 0;
        chk(last_branch ? "R3" : "R2", "fetch address", imem_addr, mpc);
        last_branch = 0;
        case (op)
            6'b000000: begin
                wr = 1; dst = rd;
                case (fn)
                    6'b100000: res = a + b;
                    6'b100010: res = a - b;
                    6'b100100: res = a & b;
                    6'b100101: res = a | b;
                    6'b101010: res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
                    default: begin wr = 0; valid = 0; end
                endcase
            end
            6'b100011: begin ea = a + sx; re_e = 1; res = mdmem[ea[7:2]]; wr = 1; dst = rt; end
            6'b101011: begin ea = a + sx; we_e = 1; mdmem[ea[7:2]] = b; end
            6'b000100: if (a == b) begin nxt = mpc + 32'd4 + (sx << 2); last_branch = 1; end
            default: valid = 0;
        endcase
        tg = !valid ? "R10" : (op == 6'b101011) ? "R7" : (op == 6'b100011) ? "R6" : "R11";
        chk(tg, "dmem_wen", {31'b0, dmem_wen}, {31'b0, we_e});
        chk(tg, "dmem_ren", {31'b0, dmem_ren}, {31'b0, re_e});
        if (we_e) begin
            chk("R7", "store address", dmem_addr, ea);
            chk("R7", "store data", dmem_wdata, b);
        end
        if (re_e) chk("R6", "load address", dmem_addr, ea);
        if (wr && dst != 0) mreg[dst] = res;
        mpc = nxt;
    endtask

    task automatic run_prog(int cycles);
        rst_n = 1'b0; mpc = '0; last_branch = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "pc held in reset", imem_addr, 32'd0);
        chk("R1", "no write in reset", {31'b0, dmem_wen}, 32'd0);
        rst_n = 1'b1;
        for (int c = 0; c < cycles; c++) begin
            step_and_check();
            @(negedge clk);
        end
    endtask

    task automatic clear_mems();
        for (int i = 0; i < MEM_WORDS; i++) begin
            imem[i] = enc_r(0, 0, 0, 6'b000000);
            dmem[i] = '0;
        end
        for (int i = 0; i < 32; i++) mreg[i] = '0;
    endtask

    task automatic sync_model();
        for (int i = 0; i < MEM_WORDS; i++) mdmem[i] = dmem[i];
    endtask

    function automatic logic [31:0] rand_ins();
        int k, rs, rt, rd, r;
        logic [5:0] fns [5];
        logic [15:0] off;
        fns[0] = 6'b100000; fns[1] = 6'b100010; fns[2] = 6'b100100;
        fns[3] = 6'b100101; fns[4] = 6'b101010;
        k = int'($urandom_range(0, 9));
        rs = int'($urandom_range(0, 7)); rt = int'($urandom_range(0, 7)); rd = int'($urandom_range(0, 7));
        case (k)
            0, 1, 2, 3, 4: return enc_r(rs, rt, rd, fns[k]);
            5: return enc_i(6'b100011, rs, rt, 16'($urandom));
            6: return enc_i(6'b101011, rs, rt, 16'($urandom));
            7: begin
                r = int'($urandom_range(0, 7));
                off = (r < 5) ? 16'(r) : 16'(-(r - 3));
                if ($urandom_range(0, 1) == 1) rt = rs;
                return enc_i(6'b000100, rs, rt, off);
            end
            8: return enc_i(6'b111111, rs, rt, 16'($urandom));
            default: return enc_r(rs, rt, rd, 6'b111111);
        endcase
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        // Directed program
        clear_mems();
        dmem[1] = 32'd5; dmem[2] = 32'hFFFF_FFFD; dmem[17] = 32'h0000_DEAD; dmem[19] = 32'h0000_1111;
        imem[0]  = enc_i(6'b100011, 0, 1, 16'd4);
        imem[1]  = enc_i(6'b100011, 0, 2, 16'd8);
        imem[2]  = enc_r(2, 1, 3, 6'b101010);
        imem[3]  = enc_i(6'b101011, 0, 3, 16'd64);
        imem[4]  = enc_r(1, 2, 4, 6'b100010);
        imem[5]  = enc_i(6'b100011, 4, 5, 16'hFFFC);
        imem[6]  = enc_r(1, 1, 0, 6'b100000);
        imem[7]  = enc_i(6'b101011, 0, 0, 16'd68);
        imem[8]  = enc_i(6'b111111, 0, 1, 16'd16);
        imem[9]  = enc_r(2, 2, 1, 6'b000000);
        imem[10] = enc_i(6'b101011, 0, 1, 16'd72);
        imem[11] = enc_i(6'b000100, 1, 5, 16'd2);
        imem[12] = enc_i(6'b101011, 0, 2, 16'd76);
        imem[13] = enc_i(6'b101011, 0, 2, 16'd76);
        imem[14] = enc_i(6'b000100, 1, 2, 16'd1);
        imem[15] = enc_r(1, 2, 6, 6'b100100);
        imem[16] = enc_r(2, 4, 7, 6'b100101);
        imem[17] = enc_i(6'b101011, 0, 6, 16'd80);
        imem[18] = enc_i(6'b101011, 0, 7, 16'd84);
        imem[19] = enc_i(6'b101011, 0, 5, 16'd88);
        imem[20] = enc_i(6'b101011, 0, 4, 16'd92);
        imem[21] = enc_i(6'b000100, 0, 0, 16'hFFFF);
        sync_model();
        run_prog(40);
        chk("R5", "signed slt -3<5", dmem[16], 32'd1);
        chk("R9", "r0 after write", dmem[17], 32'd0);
        chk("R10", "r1 after illegal ops", dmem[18], 32'd5);
        chk("R3", "stores skipped by branch", dmem[19], 32'h0000_1111);
        chk("R4", "and result", dmem[20], 32'd5);
        chk("R4", "or result", dmem[21], 32'hFFFF_FFFD);
        chk("R8", "load via -4 offset", dmem[22], 32'd5);
        chk("R4", "sub result", dmem[23], 32'd8);
        // Random programs
        for (int p = 0; p < 3; p++) begin
            clear_mems();
            for (int i = 0; i < MEM_WORDS; i++) dmem[i] = $urandom;
            for (int r = 1; r < 8; r++) imem[r-1] = enc_i(6'b100011, 0, r, 16'(4 * r));
            for (int i = 7; i < MEM_WORDS; i++) imem[i] = rand_ins();
            sync_model();
            run_prog(300);
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule